// File: doc/BRIEF.md
# Power Fault and Status-LED Controller

This block supervises the supply to a target board. Four fault flags (two regulator fault lines, an overvoltage comparator and an over-temperature comparator) are resynchronized to the local clock and merged into a single error signal. That error signal drives an error pin and forces the power-switch enable low whenever it is high. It also blanks the status LED. Three configuration bits come in as plain levels from a register file that a separate bus interface writes. They select the switch enable, the status-LED enable, and a mode that starts the slow blink clock and makes the status LED blink.

The blink clock is a gated divider chain. It runs when the blink configuration bit is set or when overvoltage is present, and it is held cleared otherwise. Because it also runs on overvoltage, the power LED can blink during an overvoltage fault even with status blinking off. Over-temperature turns the power LED off and takes precedence over overvoltage. All pins are plain control levels: there is no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `pfc_top`

## Requirements
- R1: `err_o` is the OR of the four synchronized fault inputs `rfa_fault_i`, `rfb_fault_i`, `ovp_i` and `otp_i`; reset drives it low.
- R2: Each fault input passes through two flops, so `err_o` reflects the fault levels sampled two rising edges earlier: it is low one cycle after a fault is raised and high after the second edge.
- R3: `sw_en_o` equals `cfg_sw_en_i` while `err_o` is low and is 0 while `err_o` is high.
- R4: `stat_led_o` is 0 whenever `err_o` is high.
- R5: With no error, `stat_led_o` is 0 when `cfg_led_en_i` is 0, and it is steadily 1 when `cfg_led_en_i` is 1 and `cfg_blink_en_i` is 0.
- R6: With no error and both `cfg_led_en_i` and `cfg_blink_en_i` at 1, `stat_led_o` follows the blink phase. The phase starts at 0 and toggles every `DIV_A*DIV_B` clock cycles, with the first toggle on the `DIV_A*DIV_B`-th rising edge after the blink bit is set.
- R7: The blink clock runs while `cfg_blink_en_i` or the synchronized overvoltage flag is 1. While it is stopped, the divider counters and the phase are held at 0, so a restart repeats the R6 timing from the start.
- R8: With neither overvoltage nor over-temperature present, `pwr_led_o` is 1; regulator faults do not affect it.
- R9: With synchronized overvoltage present and no over-temperature, `pwr_led_o` follows the blink phase, also when `cfg_blink_en_i` is 0.
- R10: With synchronized over-temperature present, `pwr_led_o` is 0, whatever the overvoltage state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfa_fault_i | input | 1 | First regulator fault flag |
| rfb_fault_i | input | 1 | Second regulator fault flag |
| ovp_i | input | 1 | Overvoltage comparator output |
| otp_i | input | 1 | Over-temperature comparator output |
| cfg_sw_en_i | input | 1 | Register bit requesting the power switch on |
| cfg_led_en_i | input | 1 | Register bit enabling the status LED |
| cfg_blink_en_i | input | 1 | Register bit starting the blink clock and status blinking |
| err_o | output | 1 | Combined error pin |
| sw_en_o | output | 1 | Power-switch enable |
| stat_led_o | output | 1 | Status LED drive |
| pwr_led_o | output | 1 | Power LED drive |

## Verification
On every cycle, the assertions check several rules. `err_o` must match the fault inputs two edges earlier. An error must keep both the switch and the status LED off. Over-temperature must keep the power LED dark. A stopped blink clock must clear the phase, the phase may move only on a divider wrap, and each divider count must stay in range. Only the bench scenarios can show the visible blink timing: the phase toggles after exactly `DIV_A*DIV_B` edges, a restart begins a new period, the power LED blinks under overvoltage with status blinking off, and the steady LED levels hold under each register setting.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef struct packed {
    logic rfa;
    logic rfb;
    logic ovp;
    logic otp;
  } fault_vec_t;

  localparam int unsigned FAULT_W = $bits(fault_vec_t);

  function automatic logic any_fault(input fault_vec_t f);
    return f.rfa | f.rfb | (f.ovp | f.otp);
  endfunction
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          chain[s] <= '0;
        else if (s == 0)
          chain[s] <= d_i;
        else
          chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pfc_div_stage.sv
module pfc_div_stage #(
  parameter int unsigned TERM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic step_i,
  output logic wrap_o
);
  localparam int unsigned CW = (TERM > 1) ? $clog2(TERM) : 1;
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run_i)
      cnt <= '0;
    else if (step_i)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign wrap_o = run_i & step_i & (cnt == LAST);

  // R7: a stopped clock leaves the counter at zero
  p_cnt_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt == '0));
  // R6: count never passes the terminal value
  p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/pfc_blink.sv
module pfc_blink #(
  parameter int unsigned DIV_A = 4,
  parameter int unsigned DIV_B = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic phase_o
);
  localparam int unsigned NSTAGE = 2;

  logic [NSTAGE:0] step_chain;
  logic            phase_q;

  assign step_chain[0] = run_i;

  genvar i;
  generate
    for (i = 0; i < NSTAGE; i++) begin : g_div
      pfc_div_stage #(.TERM((i == 0) ? DIV_A : DIV_B)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .step_i (step_chain[i]),
        .wrap_o (step_chain[i+1])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= 1'b0;
    else if (!run_i)
      phase_q <= 1'b0;
    else if (step_chain[NSTAGE])
      phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;

  // R7: gated-off oscillator reads a low phase
  p_phase_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !phase_q);
  // R6: phase only moves on a final-stage wrap
  p_phase_moves_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !step_chain[NSTAGE]) |=> $stable(phase_q));
endmodule

// File: rtl/pfc_led_mux.sv
module pfc_led_mux (
  input  logic err_i,
  input  logic ovp_i,
  input  logic otp_i,
  input  logic phase_i,
  input  logic sw_req_i,
  input  logic led_en_i,
  input  logic blink_en_i,
  output logic sw_en_o,
  output logic stat_led_o,
  output logic pwr_led_o
);
  always_comb begin
    sw_en_o = sw_req_i & ~err_i;

    if (err_i || !led_en_i)
      stat_led_o = 1'b0;
    else if (blink_en_i)
      stat_led_o = phase_i;
    else
      stat_led_o = 1'b1;

    if (otp_i)
      pwr_led_o = 1'b0;
    else if (ovp_i)
      pwr_led_o = phase_i;
    else
      pwr_led_o = 1'b1;
  end
endmodule

// File: rtl/pfc_top.sv
module pfc_top
  import pfc_pkg::*;
#(
  parameter int unsigned DIV_A = 1000,
  parameter int unsigned DIV_B = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfa_fault_i,
  input  logic rfb_fault_i,
  input  logic ovp_i,
  input  logic otp_i,
  input  logic cfg_sw_en_i,
  input  logic cfg_led_en_i,
  input  logic cfg_blink_en_i,
  output logic err_o,
  output logic sw_en_o,
  output logic stat_led_o,
  output logic pwr_led_o
);
  fault_vec_t raw_f, syn_f;
  logic       err, osc_run, phase;

  assign raw_f = '{rfa: rfa_fault_i, rfb: rfb_fault_i, ovp: ovp_i, otp: otp_i};

  pfc_sync #(.WIDTH(FAULT_W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_f),
    .q_o   (syn_f)
  );

  assign err     = any_fault(syn_f);
  assign osc_run = cfg_blink_en_i | syn_f.ovp;

  pfc_blink #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_blink (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (osc_run),
    .phase_o (phase)
  );

  pfc_led_mux u_mux (
    .err_i      (err),
    .ovp_i      (syn_f.ovp),
    .otp_i      (syn_f.otp),
    .phase_i    (phase),
    .sw_req_i   (cfg_sw_en_i),
    .led_en_i   (cfg_led_en_i),
    .blink_en_i (cfg_blink_en_i),
    .sw_en_o    (sw_en_o),
    .stat_led_o (stat_led_o),
    .pwr_led_o  (pwr_led_o)
  );

  assign err_o = err;

  // edges since reset, saturating, so $past never reaches into reset
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_rst <= '0;
    else if (since_rst != 2'd2)
      since_rst <= since_rst + 1'b1;
  end

  // R1, R2: error pin equals OR of the inputs two edges back
  p_err_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (err_o == ($past(rfa_fault_i, 2) | $past(rfb_fault_i, 2) |
                                        $past(ovp_i, 2) | $past(otp_i, 2))));
  // R3: error blocks the switch
  p_err_blocks_sw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !sw_en_o);
  // R4: error blanks the status LED
  p_err_blanks_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !stat_led_o);
  // R10: over-temperature seen two edges back keeps the power LED dark
  p_otp_pwr_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 2'd2) && $past(otp_i, 2)) |-> !pwr_led_o);
endmodule

// File: tb/pfc_top_tb_top.sv
`timescale 1ns/1ps
module pfc_top_tb_top;
  localparam int unsigned NA = 2;
  localparam int unsigned NB = 3;
  localparam int unsigned P  = NA * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfa = 0, rfb = 0, ovp = 0, otp = 0;
  logic sw_req = 0, led_en = 0, blink_en = 0;
  logic err, sw_en, stat_led, pwr_led;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfc_top #(.DIV_A(NA), .DIV_B(NB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rfa_fault_i(rfa), .rfb_fault_i(rfb), .ovp_i(ovp), .otp_i(otp),
    .cfg_sw_en_i(sw_req), .cfg_led_en_i(led_en), .cfg_blink_en_i(blink_en),
    .err_o(err), .sw_en_o(sw_en), .stat_led_o(stat_led), .pwr_led_o(pwr_led)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; rfa = 1; ovp = 1;
    #1;
    chk(err, 1'b0, "R1 reset err");
    chk(pwr_led, 1'b1, "R8 reset pwr");
    rfa = 0; ovp = 0;
    @(negedge clk); rst_n = 1;
    step(2);
  endtask

  task automatic t_faults;
    sw_req = 1; led_en = 1;
    step(1);
    chk(sw_en, 1'b1, "R3 sw follows req");
    chk(stat_led, 1'b1, "R5 steady on");
    for (int f = 0; f < 4; f++) begin
      rfa = (f == 0); rfb = (f == 1); ovp = (f == 2); otp = (f == 3);
      step(1);
      chk(err, 1'b0, "R2 err after one edge");
      step(1);
      chk(err, 1'b1, "R1 err on single fault");
      chk(sw_en, 1'b0, "R3 sw forced off");
      chk(stat_led, 1'b0, "R4 stat off on err");
      rfa = 0; rfb = 0; ovp = 0; otp = 0;
      step(1);
      chk(err, 1'b1, "R2 err held one edge");
      step(1);
      chk(err, 1'b0, "R2 err cleared");
      chk(sw_en, 1'b1, "R3 sw restored");
    end
    sw_req = 0;
    step(1);
    chk(sw_en, 1'b0, "R3 sw off by req");
  endtask

  task automatic t_regulator_pwr;
    rfb = 1;
    step(3);
    chk(pwr_led, 1'b1, "R8 pwr on with regulator fault");
    rfb = 0;
    step(3);
  endtask

  task automatic t_stat_modes;
    led_en = 0; blink_en = 0;
    step(1);
    chk(stat_led, 1'b0, "R5 led disabled");
    blink_en = 1;
    step(1);
    chk(stat_led, 1'b0, "R5 led disabled while blinking");
    blink_en = 0;
    step(2);
  endtask

  task automatic t_blink;
    led_en = 1; blink_en = 1;
    for (int k = 1; k <= 4 * P; k++) begin
      step(1);
      chk(stat_led, logic'((k / P) % 2), "R6 status blink phase");
    end
    blink_en = 0;
    step(1);
    chk(stat_led, 1'b1, "R5 steady after blink off");
    // R7 restart: stop mid-period, then verify fresh timing
    blink_en = 1;
    step(P + 2);
    blink_en = 0;
    step(1);
    blink_en = 1;
    for (int k = 1; k <= 2 * P; k++) begin
      step(1);
      chk(stat_led, logic'((k / P) % 2), "R7 restart timing");
    end
    blink_en = 0; led_en = 0;
    step(2);
  endtask

  task automatic t_ovp_pwr;
    ovp = 1;
    step(1);
    chk(pwr_led, 1'b1, "R9 pwr before sync");
    for (int k = 2; k <= 4 * P + 2; k++) begin
      step(1);
      chk(pwr_led, logic'(((k - 2) / P) % 2), "R9 pwr blinks on ovp");
    end
    ovp = 0;
    step(2);
    chk(pwr_led, 1'b1, "R8 pwr on after ovp");
    step(2);
  endtask

  task automatic t_otp_pwr;
    ovp = 1; otp = 1;
    step(2);
    for (int k = 0; k < 3 * P; k++) begin
      chk(pwr_led, 1'b0, "R10 pwr off on otp over ovp");
      step(1);
    end
    chk(err, 1'b1, "R1 err on otp");
    ovp = 0; otp = 0;
    step(2);
    chk(pwr_led, 1'b1, "R8 pwr restored");
    chk(err, 1'b0, "R1 err cleared");
  endtask

  initial begin
    t_reset();
    t_faults();
    t_regulator_pwr();
    t_stat_modes();
    t_blink();
    t_ovp_pwr();
    t_otp_pwr();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule